// File: doc/BRIEF.md
# Serial Waveform Byte Loader

The block takes waveform samples from a slow serial host link and writes them, one byte at a time, into an external byte-wide SRAM. The host drives a serial clock, a serial data line and a two-bit mode code. All three are synchronous to the system clock `clk`. The block finds the serial clock edges by comparing each sample with the one before. In mode `11` each falling serial edge shifts one data bit into an 8-bit register, most significant bit first. A rising serial edge in mode `10` copies that byte onto the SRAM data pins and advances the 15-bit write address. The falling serial edge that follows, still in mode `10`, pulls write enable low so the byte lands at the new address.

A rising serial edge in mode `00` puts the SRAM into read mode. Output enable goes low, the `enable_o` status goes high, and the sample-rate tick is passed through to the playback counter. Mode `01` belongs to another register on the same link, and this block ignores it.

The controller is a five-state machine:
- IDLE is the state after reset.
- SHIFT collects bits.
- LATCH holds the byte with its new address.
- WRITE holds write enable low.
- RUN is playback.

The named transitions are:
- go_shift: any rising edge in mode `11`, from any state, enters SHIFT.
- go_latch: a rising edge in mode `10` moves SHIFT to LATCH.
- go_write: a falling edge in mode `10` moves LATCH to WRITE.
- go_run: any rising edge in mode `00`, from any state, enters RUN.

Top module: `wave_sram_loader`

## Requirements
- R1: After reset, sram_we_n and sram_oe_n are high, enable_o and rate_tick_o are low, and sram_addr is all ones (32767).
- R2: In mode 11, each falling edge of host_sclk shifts host_sdi into the byte register, so the first bit sent becomes bit 7 of the byte and the eighth bit becomes bit 0.
- R3: A rising edge of host_sclk in mode 11 drives enable_o low and sram_oe_n high in the next cycle.
- R4: sram_we_n stays high for the whole shift phase of a byte (mode 11).
- R5: A rising edge of host_sclk in mode 10, taken from the shift phase, places the assembled byte on sram_data and increments sram_addr by one, while sram_we_n stays high.
- R6: The next falling edge of host_sclk in mode 10 drives sram_we_n low, so the byte is written at the incremented address. sram_we_n stays low until the next rising edge in mode 11 or 00.
- R7: The write address is 15 bits and wraps from 32767 to 0, so the first byte written after reset lands at address 0.
- R8: A rising edge of host_sclk in mode 00 drives sram_oe_n low, enable_o high and sram_we_n high. While in that run state, rate_tick_o follows sample_tick_i. In every other state rate_tick_o is 0.
- R9: sram_we_n and sram_oe_n are never low at the same time.
- R10: Serial clock edges in mode 01 change neither the state, the byte register, sram_data nor sram_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sclk | input | 1 | Serial clock from the host, synchronous to clk |
| host_sdi | input | 1 | Serial data bit, valid while host_sclk is high |
| mode_i | input | 2 | Mode code: 11 shift, 10 latch/write, 00 run, 01 ignored |
| sample_tick_i | input | 1 | Selected sample-rate tick |
| sram_addr | output | 15 | SRAM address |
| sram_data | output | 8 | SRAM write data (latched byte) |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| enable_o | output | 1 | High in run mode, low while loading |
| rate_tick_o | output | 1 | Sample tick gated through in run mode |

## Verification
The hardest situation to reach from the ports is a serial edge in mode 01 that falls in the middle of a byte. To stay invisible it must leave the partial byte intact. The bench therefore sends four bits, pulses the host clock with mode 01, and then sends the last four. It checks that the byte written matches the eight real bits alone. The address wrap is reached without loading 32768 bytes: reset leaves the counter at its top value, so the first write after reset has to land at address 0.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SHIFT = 3'd1,
        ST_LATCH = 3'd2,
        ST_WRITE = 3'd3,
        ST_RUN   = 3'd4
    } wsl_state_t;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_OTHER = 2'b01;
    localparam logic [1:0] MODE_LATCH = 2'b10;
    localparam logic [1:0] MODE_SHIFT = 2'b11;
endpackage

// File: rtl/wsl_edge.sv
module wsl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
    assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/wsl_byte.sv
module wsl_byte #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              latch_en,
    input  logic              sdi,
    output logic [DATA_W-1:0] byte_o
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            byte_o <= '0;
        end else begin
            if (shift_en) shreg  <= {shreg[DATA_W-2:0], sdi};
            if (latch_en) byte_o <= shreg;
        end
    end
endmodule

// File: rtl/wsl_addr.sv
module wsl_addr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_o <= '1;
        else if (inc) addr_o <= addr_o + 1'b1;
    end
endmodule

// File: rtl/wave_sram_loader.sv
module wave_sram_loader
    import wsl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_sdi,
    input  logic [1:0]        mode_i,
    input  logic              sample_tick_i,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_data,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              enable_o,
    output logic              rate_tick_o
);
    wsl_state_t state, state_nxt;
    logic       sclk_rise, sclk_fall;
    logic       shift_en, latch_en;
    logic       run_q;

    wsl_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (host_sclk),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    assign shift_en = sclk_fall && (mode_i == MODE_SHIFT) && (state == ST_SHIFT);
    assign latch_en = sclk_rise && (mode_i == MODE_LATCH) && (state == ST_SHIFT);

    wsl_byte #(.DATA_W(DATA_W)) u_byte (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .latch_en (latch_en),
        .sdi      (host_sdi),
        .byte_o   (sram_data)
    );

    wsl_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (latch_en),
        .addr_o (sram_addr)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (sclk_rise) begin
            unique case (mode_i)
                MODE_SHIFT: state_nxt = ST_SHIFT;                   // go_shift
                MODE_RUN:   state_nxt = ST_RUN;                     // go_run
                MODE_LATCH: if (state == ST_SHIFT) state_nxt = ST_LATCH; // go_latch
                MODE_OTHER: state_nxt = state;                      // R10: ignored
            endcase
        end else if (sclk_fall && (mode_i == MODE_LATCH) && (state == ST_LATCH)) begin
            state_nxt = ST_WRITE;                                   // go_write
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        sram_we_n = 1'b1;
        sram_oe_n = 1'b1;
        run_q     = 1'b0;
        unique case (state)
            ST_IDLE, ST_SHIFT, ST_LATCH: ;
            ST_WRITE: sram_we_n = 1'b0;
            ST_RUN: begin
                sram_oe_n = 1'b0;
                run_q     = 1'b1;
            end
            default: ;
        endcase
    end

    assign enable_o    = run_q;
    assign rate_tick_o = run_q & sample_tick_i;
endmodule

// File: rtl/wave_sram_loader_chk.sv
module wave_sram_loader_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              enable_o
);
    assert_we_oe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    assert_we_after_latch_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(mode_i) == 2'b10);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sram_addr) |-> (sram_addr == $past(sram_addr) + 1'b1) && ($past(mode_i) == 2'b10));

    assert_run_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_o) |-> $past(mode_i) == 2'b00);

    assert_no_write_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !enable_o);

    assert_shift_leaves_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable_o) |-> $past(mode_i) == 2'b11);
endmodule

bind wave_sram_loader wave_sram_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .sram_addr (sram_addr),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .enable_o  (enable_o)
);

// File: tb/wave_sram_loader_tb.sv
module wave_sram_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sclk = 1'b0;
    logic        host_sdi = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        sample_tick_i = 1'b0;
    logic [14:0] sram_addr;
    logic [7:0]  sram_data;
    logic        sram_we_n, sram_oe_n, enable_o, rate_tick_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] mem [int];

    always #5 clk = ~clk;

    wave_sram_loader u_dut (
        .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .host_sdi(host_sdi),
        .mode_i(mode_i), .sample_tick_i(sample_tick_i), .sram_addr(sram_addr),
        .sram_data(sram_data), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .enable_o(enable_o), .rate_tick_o(rate_tick_o)
    );

    // SRAM model
    always @(posedge clk) if (!sram_we_n) mem[int'(sram_addr)] = sram_data;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: expired, actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edge_to(input logic lvl, input logic [1:0] m);
        mode_i = m;
        host_sclk = lvl;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        host_sdi = b;
        edge_to(1'b1, 2'b11);
        check("R4", int'(sram_we_n), 1);
        edge_to(1'b0, 2'b11);
    endtask

    task automatic latch_write(input int exp_addr, input logic [7:0] exp_byte);
        edge_to(1'b1, 2'b10);
        check("R5 addr", int'(sram_addr), exp_addr);
        check("R5 data", int'(sram_data), int'(exp_byte));
        check("R5 we", int'(sram_we_n), 1);
        edge_to(1'b0, 2'b10);
        check("R6 we", int'(sram_we_n), 0);
        @(negedge clk);
        check("R6 mem", mem.exists(exp_addr) ? int'(mem[exp_addr]) : -1, int'(exp_byte));
    endtask

    typedef struct packed { logic [7:0] b; logic [14:0] a; } vec_t;
    localparam vec_t VECS [5] = '{
        '{8'hA5, 15'd0}, '{8'h3C, 15'd1}, '{8'hFF, 15'd2},
        '{8'h00, 15'd3}, '{8'h81, 15'd4}
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R1 we", int'(sram_we_n), 1);
        check("R1 oe", int'(sram_oe_n), 1);
        check("R1 en", int'(enable_o), 0);
        check("R1 addr", int'(sram_addr), 32'h7FFF);
        rst_n = 1'b1;
        @(negedge clk);

        // table of bytes, R2/R7: first write wraps to 0
        for (int v = 0; v < 5; v++) begin
            for (int i = 7; i >= 0; i--) send_bit(VECS[v].b[i]);
            latch_write(int'(VECS[v].a), VECS[v].b);
            if (v == 0) check("R7 wrap", int'(sram_addr), 0);
        end
        check("R2 msb", int'(mem[1]), 32'h3C);

        // R8: enter run
        edge_to(1'b1, 2'b00);
        check("R8 oe", int'(sram_oe_n), 0);
        check("R8 en", int'(enable_o), 1);
        check("R8 we", int'(sram_we_n), 1);
        sample_tick_i = 1'b1; #1;
        check("R8 tick", int'(rate_tick_o), 1);
        sample_tick_i = 1'b0; #1;
        check("R8 tick low", int'(rate_tick_o), 0);
        edge_to(1'b0, 2'b00);

        // R10: mode 01 edges in run change nothing
        edge_to(1'b1, 2'b01);
        edge_to(1'b0, 2'b01);
        check("R10 en", int'(enable_o), 1);
        check("R10 addr", int'(sram_addr), 4);
        check("R10 data", int'(sram_data), 32'h81);

        // R3: shift start leaves run
        host_sdi = 1'b0;
        edge_to(1'b1, 2'b11);
        check("R3 en", int'(enable_o), 0);
        check("R3 oe", int'(sram_oe_n), 1);
        sample_tick_i = 1'b1; #1;
        check("R8 tick gated", int'(rate_tick_o), 0);
        sample_tick_i = 1'b0;
        edge_to(1'b0, 2'b11);

        // R10: mode 01 pulse mid-byte; byte 0b0110_1001 = 8'h69
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        host_sdi = 1'b1;
        edge_to(1'b1, 2'b01);
        edge_to(1'b0, 2'b01);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        latch_write(5, 8'h69);
        check("R10 midbyte", int'(sram_data), 32'h69);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule